// File: doc/BRIEF.md
# Read-Data Parity Error Reporter

This block sits on one bus interface of a bridge, at the point where read data comes back from a target. It checks even parity over each completed data phase. The parity bit for a data phase arrives one clock after that phase, so the block holds the data for one cycle and checks it then.

When the check fails, the block does three things:
- It sets sticky status bits. Software clears each bit by writing one to it.
- If reporting is enabled, it drives an active-low error line two clocks after the bad transfer.
- It leaves the transaction running.

Each checked word goes into a small buffer, together with the parity bit exactly as it was received. The buffer forwards the words toward the initiator on the other bus. A discard input drops prefetched words that the initiator never reads, so no bad parity is ever returned for them. An error line driven by that initiator is ignored.

Top module: `rdpar_reporter`

## Requirements
- R1: `sts_det` is set one clock after the parity check of any data phase fails, whatever the value of `perr_en`. Parity is even: a phase is bad when `dp_par` differs from the XOR of all `dp_data` bits and all `dp_be` bits.
- R2: `sts_dpd` is set on a failed check only when `perr_en` is 1 in the cycle in which the parity bit is sampled. That cycle is the clock after the data phase.
- R3: `perr_n` goes low for exactly one cycle per bad data phase. It is low in the cycle after the second rising edge that follows the edge where `dp_done` was sampled, and only if `perr_en` was 1 in the cycle in which that phase's parity bit was sampled. Back-to-back bad phases give back-to-back low cycles.
- R4: The buffer keeps every checked word in order. `fwd_data`, `fwd_be` and `fwd_par` show the word at its head, with the parity exactly as received (never regenerated). `fwd_rd` pops the head word while `fwd_valid` is 1.
- R5: `fwd_discard` empties the buffer, so the dropped words are never presented. A word being checked in the same cycle as the discard is kept. The discard has no effect on the status bits or on `perr_n`.
- R6: `init_perr_n` has no effect on the status bits, on `perr_n` or on the forwarded words.
- R7: Each status bit stays set until a one is written to its clear input (`clr_det`, `clr_dpd`). If a clear and a new error arrive in the same cycle, the bit stays set.
- R8: A synchronous active-low reset makes `perr_n` high, clears both status bits and empties the buffer.
- R9: A parity error never stops the flow. Every completed data phase is checked and forwarded, good or bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| perr_en | input | 1 | Parity-error-response enable |
| dp_done | input | 1 | Read data phase completed in this cycle |
| dp_data | input | 32 | Read data |
| dp_be | input | 4 | Byte enables of the data phase |
| dp_par | input | 1 | Parity bit, valid one clock after its data phase |
| init_perr_n | input | 1 | Error line from the initiator (ignored) |
| clr_det | input | 1 | Write-one-to-clear for `sts_det` |
| clr_dpd | input | 1 | Write-one-to-clear for `sts_dpd` |
| fwd_rd | input | 1 | Initiator consumes the head word |
| fwd_discard | input | 1 | Drop all buffered prefetch words |
| perr_n | output | 1 | Active-low parity error report |
| sts_det | output | 1 | Sticky: parity error detected |
| sts_dpd | output | 1 | Sticky: data parity error reported |
| fwd_valid | output | 1 | Buffer holds a word |
| fwd_data | output | 32 | Head word data |
| fwd_be | output | 4 | Head word byte enables |
| fwd_par | output | 1 | Head word parity, as received |

## Verification
The hardest case to reach from the ports is the overlap of several things: bad data phases arriving back to back while the enable toggles, a clear landing on the same edge as a new error, and a discard in the same cycle as a word being pushed. The bench first sweeps a single set bit across all 36 covered bit positions, once with good parity and once with bad parity, in consecutive phases. It then runs a long pseudo-random stretch with a cycle-level model that predicts every output.

// File: rtl/rdpar_pkg.sv
// Package: shared widths and the forwarded word type for the parity reporter.
// Assumes one data phase of DATA_W bits covered by BE_W byte-enable bits.
package rdpar_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = 4;

    typedef struct packed {
        logic              par;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } fwd_word_t;
endpackage

// File: rtl/rdpar_check.sv
// Module: holds a completed data phase for one clock and checks it against the
// parity bit that arrives in that following cycle (even parity over data and
// byte enables). Assumes dp_par is meaningful only in the cycle after dp_done.
module rdpar_check
    import rdpar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_done,
    input  logic [DATA_W-1:0] dp_data,
    input  logic [BE_W-1:0]   dp_be,
    input  logic              dp_par,
    output logic              chk_valid,
    output logic              chk_err,
    output fwd_word_t         chk_word
);
    logic              hold_v;
    logic [DATA_W-1:0] hold_data;
    logic [BE_W-1:0]   hold_be;

    // Capture the data phase while its parity bit is still on its way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_data <= '0;
            hold_be   <= '0;
        end else begin
            hold_v <= dp_done;
            if (dp_done) begin
                hold_data <= dp_data;
                hold_be   <= dp_be;
            end
        end
    end

    // Compare the late parity bit with the parity of the held phase.
    always_comb begin
        chk_valid      = hold_v;
        chk_err        = hold_v & ((^{hold_data, hold_be}) ^ dp_par);
        chk_word.data  = hold_data;
        chk_word.be    = hold_be;
        chk_word.par   = dp_par;
    end
endmodule

// File: rtl/rdpar_report.sv
// Module: turns detected errors into the delayed active-low error line and the
// two sticky status bits. Assumes chk_err is already qualified by a valid phase.
module rdpar_report #(
    parameter int PERR_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic perr_en,
    input  logic chk_err,
    input  logic clr_det,
    input  logic clr_dpd,
    output logic perr_n,
    output logic sts_det,
    output logic sts_dpd
);
    logic [PERR_LAT-1:0] dly;

    // Delay line for enabled errors: one stage per clock of report latency.
    genvar g;
    generate
        for (g = 0; g < PERR_LAT; g++) begin : g_dly
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) dly[0] <= 1'b0;
                    else        dly[0] <= chk_err & perr_en;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) dly[g] <= 1'b0;
                    else        dly[g] <= dly[g-1];
                end
            end
        end
    endgenerate

    assign perr_n = ~dly[PERR_LAT-1];

    // Sticky status: a new error outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_det <= 1'b0;
            sts_dpd <= 1'b0;
        end else begin
            sts_det <= (sts_det & ~clr_det) | chk_err;
            sts_dpd <= (sts_dpd & ~clr_dpd) | (chk_err & perr_en);
        end
    end

    AST_PERR_AFTER_DET: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(sts_det)); // R3
    AST_DPD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_dpd) |-> $past(perr_en)); // R2
    AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_det && !clr_det) |=> sts_det); // R7
    AST_DPD_IMPLIES_DET_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_dpd) |-> $rose(sts_det) || sts_det); // R1
endmodule

// File: rtl/rdpar_fwd_buf.sv
// Module: in-order buffer of checked words heading to the initiator. Parity
// travels unchanged. A discard empties it but keeps a word pushed that cycle.
// Assumes the upstream flow control never pushes into a full buffer.
module rdpar_fwd_buf
    import rdpar_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  fwd_word_t push_word,
    input  logic      pop,
    input  logic      discard,
    output logic      valid,
    output fwd_word_t head
);
    localparam int PTR_W = $clog2(DEPTH);

    fwd_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;
    logic             do_pop;

    assign do_pop = pop & (count != 0) & ~discard;
    assign valid  = (count != 0);
    assign head   = mem[rd_ptr];

    // Storage write: every checked word lands at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
    end

    // Pointer and occupancy update, with discard taking precedence over pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push);
            if (discard) begin
                rd_ptr <= wr_ptr;
                count  <= (PTR_W+1)'(push);
            end else begin
                rd_ptr <= rd_ptr + PTR_W'(do_pop);
                count  <= count + (PTR_W+1)'(push) - (PTR_W+1)'(do_pop);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < (PTR_W+1)'(DEPTH)) || discard || pop); // R4
    AST_DISCARD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (discard && !push) |=> !valid); // R5
endmodule

// File: rtl/rdpar_reporter.sv
// Module: top of the read-data parity reporter. Checks parity, reports errors
// and forwards words with their received parity. Assumes the initiator error
// line is informational only: it is accepted and deliberately unused.
module rdpar_reporter
    import rdpar_pkg::*;
#(
    parameter int FWD_DEPTH = 4,
    parameter int PERR_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              perr_en,
    input  logic              dp_done,
    input  logic [DATA_W-1:0] dp_data,
    input  logic [BE_W-1:0]   dp_be,
    input  logic              dp_par,
    input  logic              init_perr_n,
    input  logic              clr_det,
    input  logic              clr_dpd,
    input  logic              fwd_rd,
    input  logic              fwd_discard,
    output logic              perr_n,
    output logic              sts_det,
    output logic              sts_dpd,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic [BE_W-1:0]   fwd_be,
    output logic              fwd_par
);
    logic      chk_valid, chk_err;
    fwd_word_t chk_word, head;
    logic      unused_init;

    // The initiator owns errors on data it receives; its line is not used.
    assign unused_init = init_perr_n;

    rdpar_check i_check (
        .clk(clk), .rst_n(rst_n), .dp_done(dp_done), .dp_data(dp_data),
        .dp_be(dp_be), .dp_par(dp_par), .chk_valid(chk_valid),
        .chk_err(chk_err), .chk_word(chk_word)
    );

    rdpar_report #(.PERR_LAT(PERR_LAT)) i_report (
        .clk(clk), .rst_n(rst_n), .perr_en(perr_en), .chk_err(chk_err),
        .clr_det(clr_det), .clr_dpd(clr_dpd), .perr_n(perr_n),
        .sts_det(sts_det), .sts_dpd(sts_dpd)
    );

    rdpar_fwd_buf #(.DEPTH(FWD_DEPTH)) i_buf (
        .clk(clk), .rst_n(rst_n), .push(chk_valid), .push_word(chk_word),
        .pop(fwd_rd), .discard(fwd_discard), .valid(fwd_valid), .head(head)
    );

    assign fwd_data = head.data;
    assign fwd_be   = head.be;
    assign fwd_par  = head.par;

    AST_ERR_SETS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |=> sts_det); // R1
    AST_CHECKED_WORD_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> fwd_valid); // R9
endmodule

// File: tb/test_rdpar_reporter.sv
`timescale 1ns/1ps
module test_rdpar_reporter;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n, perr_en, dp_done, dp_par, init_perr_n;
    logic clr_det, clr_dpd, fwd_rd, fwd_discard;
    logic [31:0] dp_data;
    logic [3:0]  dp_be;
    logic perr_n, sts_det, sts_dpd, fwd_valid, fwd_par;
    logic [31:0] fwd_data;
    logic [3:0]  fwd_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rdpar_reporter i_rdpar_reporter (
        .clk(clk), .rst_n(rst_n), .perr_en(perr_en), .dp_done(dp_done),
        .dp_data(dp_data), .dp_be(dp_be), .dp_par(dp_par),
        .init_perr_n(init_perr_n), .clr_det(clr_det), .clr_dpd(clr_dpd),
        .fwd_rd(fwd_rd), .fwd_discard(fwd_discard), .perr_n(perr_n),
        .sts_det(sts_det), .sts_dpd(sts_dpd), .fwd_valid(fwd_valid),
        .fwd_data(fwd_data), .fwd_be(fwd_be), .fwd_par(fwd_par)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model state derived from the requirements
    logic        m_v, m_pend_par, m_s0, e_perr_n, e_det, e_dpd, err;
    logic [31:0] m_d;
    logic [3:0]  m_be;
    logic [36:0] q[$];

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic bad;
        rst_n = 0; perr_en = 0; dp_done = 0; dp_data = 0; dp_be = 0; dp_par = 1;
        init_perr_n = 1; clr_det = 0; clr_dpd = 0; fwd_rd = 0; fwd_discard = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "perr_n", perr_n, 1);
        chk("R8", "sts_det", sts_det, 0);
        chk("R8", "sts_dpd", sts_dpd, 0);
        chk("R8", "fwd_valid", fwd_valid, 0);
        rst_n = 1;
        m_v = 0; m_pend_par = 0; m_s0 = 0; e_perr_n = 1; e_det = 0; e_dpd = 0;
        m_d = 0; m_be = 0;
        for (int c = 0; c < 3000; c++) begin
            if (c > 0) @(negedge clk);
            chk("R3", "perr_n", perr_n, e_perr_n);
            chk("R1 R6 R7", "sts_det", sts_det, e_det);
            chk("R2 R7", "sts_dpd", sts_dpd, e_dpd);
            chk("R4 R5 R9", "fwd_valid", fwd_valid, q.size() != 0);
            if (q.size() != 0)
                chk("R4", "fwd word", {fwd_par, fwd_be, fwd_data}, q[0]);
            // choose stimulus
            if (c < 72) begin
                int b = c / 2;
                bad = c[0];
                dp_done = 1;
                dp_data = (b < 32) ? (32'h1 << b) : 32'h0;
                dp_be   = (b < 32) ? 4'h0 : (4'h1 << (b - 32));
                perr_en = c[2];
                clr_det = (c % 9 == 8); clr_dpd = (c % 7 == 6);
                init_perr_n = ~c[1]; fwd_rd = 1; fwd_discard = 0;
            end else begin
                dp_done = ($urandom_range(0, 2) != 0) && (q.size() + m_v <= 2);
                dp_data = $urandom();
                dp_be   = 4'($urandom());
                bad     = ($urandom_range(0, 3) == 0);
                perr_en = ($urandom_range(0, 3) != 0);
                clr_det = ($urandom_range(0, 9) == 0);
                clr_dpd = ($urandom_range(0, 9) == 0);
                init_perr_n = ($urandom_range(0, 3) != 0);
                fwd_rd  = $urandom_range(0, 1);
                fwd_discard = ($urandom_range(0, 15) == 0);
            end
            dp_par = m_v ? m_pend_par : 1'($urandom());
            // model update at the coming rising edge
            err      = m_v && (dp_par != (^{m_d, m_be}));
            e_perr_n = ~m_s0;
            m_s0     = err & perr_en;
            e_det    = (e_det & ~clr_det) | err;
            e_dpd    = (e_dpd & ~clr_dpd) | (err & perr_en);
            if (fwd_discard) q.delete();
            else if (fwd_rd && q.size() != 0) void'(q.pop_front());
            if (m_v) q.push_back({dp_par, m_be, m_d});
            m_v = dp_done;
            if (dp_done) begin
                m_d = dp_data; m_be = dp_be;
                m_pend_par = (^{dp_data, dp_be}) ^ bad;
            end
        end
        @(negedge clk);
        chk("R3", "perr_n final", perr_n, e_perr_n);
        chk("R1", "sts_det final", sts_det, e_det);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule